// File: doc/BRIEF.md
# Frame Preemption Control and Status Register

This block is the register front end for frame preemption in an Ethernet MAC. Software reaches it over a simple single-cycle register bus. Through it, software turns preemption on or off and asks the transmitter to send a verify or a response handshake packet. It also programs how large the extra fragment is and which transmit queues may be preempted. The packet engines themselves are not part of this block. Each send request leaves as a one-cycle strobe, and each handshake event comes back in as a one-cycle strobe.

The control word mixes two kinds of bit. The enable bit is persistent. The two send bits are one-shot requests and never read back as set. The same word also carries four sticky event flags. Any event strobe sets its flag, and reading the word clears all four. An interrupt line is raised while any flag is set and the separate interrupt-enable bit is on. Before setting the enable, software is expected to read the control word once so that events gathered while the interrupt was masked are thrown away.

The bus is not a stream, so it has no valid/ready handshake. A transfer is one cycle long and has `bus_sel` high. `bus_wr` chooses between write and read. Read data is combinational from the registers during that cycle, and the clear that the read causes takes effect at the closing clock edge.

Top module: `pcsr_top`

## Requirements
- R1: After reset, every register is zero: enable, interrupt enable, fragment size, queue mask and the four flags. All outputs are low and a read of any word returns 0.
- R2: Bit 0 of word 0 is the preemption enable. A write to word 0 loads it and it drives `preempt_en`. It holds its value until word 0 is written again, whatever the other bits of that write contain.
- R3: A write to word 0 with bit 1 set drives `tx_verify_req` high for exactly the one cycle after the write. Bit 2 does the same for `tx_response_req`. Both bits always read back as 0.
- R4: Each event strobe sets its own flag in word 0: received verify at bit 16, received response at bit 17, transmitted verify at bit 18, transmitted response at bit 19. A flag stays set until it is cleared.
- R5: A read of word 0 returns the flags as they stand in that cycle and then clears all four. A second read with no new events in between returns 0 in bits 19:16.
- R6: An event strobe that comes in the same cycle as a clearing read leaves its flag set after that read.
- R7: Bit 0 of word 1 is the interrupt enable and reads back as written. `irq` is high exactly while that enable is on and at least one flag is set.
- R8: If word 0 is read and the interrupt is enabled afterwards, with no event in between, `irq` stays low. Events gathered while the interrupt was masked are lost.
- R9: Word 2 holds the additional fragment size in bits 1:0 and the preemptible queue mask in bits 15:8. They drive `frag_size` and `preempt_qmask`, and every other bit of word 2 reads 0.
- R10: Writes cannot set or clear the flags. Reads of words 1 and 2 leave the flags unchanged. Words 3 and above read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus transfer in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 4 | Word index (0 control/status, 1 interrupt enable, 2 queue config) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read |
| ev_rx_verify | input | 1 | Strobe: a verify packet was received |
| ev_rx_response | input | 1 | Strobe: a response packet was received |
| ev_tx_verify | input | 1 | Strobe: a verify packet was transmitted |
| ev_tx_response | input | 1 | Strobe: a response packet was transmitted |
| preempt_en | output | 1 | Preemption enable |
| tx_verify_req | output | 1 | One-cycle request to send a verify packet |
| tx_response_req | output | 1 | One-cycle request to send a response packet |
| frag_size | output | 2 | Additional fragment size |
| preempt_qmask | output | 8 | Preemptible transmit queue mask |
| irq | output | 1 | Interrupt, flags gated by the enable |

## Verification
A flag that was lost or stuck shows up on the next read of word 0. If the interrupt is enabled, it shows up on `irq` one cycle after the event edge. A request bit that stays set for more than one cycle shows up on the request pin in the second cycle after the write. A request bit that leaks into the enable register shows up as a wrong `preempt_en` in the same cycle. A read that clears a flag it should not clear, such as a read of another word or a read that coincides with an event, shows up on the very next read of word 0.

// File: rtl/pcsr_pkg.sv
package pcsr_pkg;
  localparam int DATA_W     = 32;
  localparam int NUM_EV     = 4;
  localparam int EN_BIT     = 0;
  localparam int VFY_BIT    = 1;
  localparam int RSP_BIT    = 2;
  localparam int STS_LSB    = 16;
  localparam int IRQEN_BIT  = 0;
  localparam int FRAG_LSB   = 0;
  localparam int QMASK_LSB  = 8;
  localparam int WORD_CTRL  = 0;
  localparam int WORD_IRQEN = 1;
  localparam int WORD_QCFG  = 2;

  // event order equals flag order from STS_LSB upward
  typedef enum logic [1:0] {
    EV_RX_VFY = 2'd0,
    EV_RX_RSP = 2'd1,
    EV_TX_VFY = 2'd2,
    EV_TX_RSP = 2'd3
  } ev_idx_e;
endpackage

// File: rtl/pcsr_decode.sv
module pcsr_decode #(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 32,
  parameter int NUM_EV  = 4,
  parameter int QMASK_W = 8,
  parameter int FRAG_W  = 2
) (
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               en_q,
  input  logic               irq_en_q,
  input  logic [FRAG_W-1:0]  frag_q,
  input  logic [QMASK_W-1:0] qmask_q,
  input  logic [NUM_EV-1:0]  flags_q,
  output logic               wr_ctrl,
  output logic               wr_irqen,
  output logic               wr_qcfg,
  output logic               rd_clear,
  output logic [DATA_W-1:0]  rdata
);
  import pcsr_pkg::*;

  logic hit_ctrl, hit_irqen, hit_qcfg;

  assign hit_ctrl  = (bus_addr == ADDR_W'(WORD_CTRL));
  assign hit_irqen = (bus_addr == ADDR_W'(WORD_IRQEN));
  assign hit_qcfg  = (bus_addr == ADDR_W'(WORD_QCFG));

  assign wr_ctrl  = bus_sel & bus_wr & hit_ctrl;
  assign wr_irqen = bus_sel & bus_wr & hit_irqen;
  assign wr_qcfg  = bus_sel & bus_wr & hit_qcfg;
  assign rd_clear = bus_sel & ~bus_wr & hit_ctrl;

  always_comb begin
    rdata = '0;
    if (bus_sel && !bus_wr) begin
      if (hit_ctrl) begin
        rdata[EN_BIT]                 = en_q;
        rdata[STS_LSB +: NUM_EV]      = flags_q;
      end else if (hit_irqen) begin
        rdata[IRQEN_BIT]              = irq_en_q;
      end else if (hit_qcfg) begin
        rdata[FRAG_LSB +: FRAG_W]     = frag_q;
        rdata[QMASK_LSB +: QMASK_W]   = qmask_q;
      end
    end
  end
endmodule

// File: rtl/pcsr_status.sv
module pcsr_status #(
  parameter int NUM_EV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_clear,
  input  logic [NUM_EV-1:0] ev,
  output logic [NUM_EV-1:0] flags_q
);
  for (genvar i = 0; i < NUM_EV; i++) begin : g_flag
    // a new event wins over the clearing read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= (flags_q[i] & ~rd_clear) | ev[i];
    end
  end
endmodule

// File: rtl/pcsr_ctrl.sv
module pcsr_ctrl #(
  parameter int QMASK_W = 8,
  parameter int FRAG_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_ctrl,
  input  logic               wr_irqen,
  input  logic               wr_qcfg,
  input  logic               wd_en,
  input  logic               wd_vfy,
  input  logic               wd_rsp,
  input  logic               wd_irqen,
  input  logic [FRAG_W-1:0]  wd_frag,
  input  logic [QMASK_W-1:0] wd_qmask,
  output logic               en_q,
  output logic               vfy_req_q,
  output logic               rsp_req_q,
  output logic               irq_en_q,
  output logic [FRAG_W-1:0]  frag_q,
  output logic [QMASK_W-1:0] qmask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      vfy_req_q <= 1'b0;
      rsp_req_q <= 1'b0;
      irq_en_q  <= 1'b0;
      frag_q    <= '0;
      qmask_q   <= '0;
    end else begin
      // request bits live one cycle only
      vfy_req_q <= wr_ctrl & wd_vfy;
      rsp_req_q <= wr_ctrl & wd_rsp;
      if (wr_ctrl)  en_q     <= wd_en;
      if (wr_irqen) irq_en_q <= wd_irqen;
      if (wr_qcfg) begin
        frag_q  <= wd_frag;
        qmask_q <= wd_qmask;
      end
    end
  end
endmodule

// File: rtl/pcsr_top.sv
module pcsr_top #(
  parameter int ADDR_W  = 4,
  parameter int QMASK_W = 8,
  parameter int FRAG_W  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [pcsr_pkg::DATA_W-1:0] bus_wdata,
  output logic [pcsr_pkg::DATA_W-1:0] bus_rdata,
  input  logic                       ev_rx_verify,
  input  logic                       ev_rx_response,
  input  logic                       ev_tx_verify,
  input  logic                       ev_tx_response,
  output logic                       preempt_en,
  output logic                       tx_verify_req,
  output logic                       tx_response_req,
  output logic [FRAG_W-1:0]          frag_size,
  output logic [QMASK_W-1:0]         preempt_qmask,
  output logic                       irq
);
  import pcsr_pkg::*;

  logic              wr_ctrl, wr_irqen, wr_qcfg, rd_clear;
  logic              en_q, vfy_req_q, rsp_req_q, irq_en_q;
  logic [FRAG_W-1:0]  frag_q;
  logic [QMASK_W-1:0] qmask_q;
  logic [NUM_EV-1:0]  ev_vec;
  logic [NUM_EV-1:0]  flags_q;

  assign ev_vec[EV_RX_VFY] = ev_rx_verify;
  assign ev_vec[EV_RX_RSP] = ev_rx_response;
  assign ev_vec[EV_TX_VFY] = ev_tx_verify;
  assign ev_vec[EV_TX_RSP] = ev_tx_response;

  pcsr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_EV(NUM_EV),
    .QMASK_W(QMASK_W), .FRAG_W(FRAG_W)
  ) u_dec (
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .en_q(en_q), .irq_en_q(irq_en_q), .frag_q(frag_q), .qmask_q(qmask_q),
    .flags_q(flags_q),
    .wr_ctrl(wr_ctrl), .wr_irqen(wr_irqen), .wr_qcfg(wr_qcfg),
    .rd_clear(rd_clear), .rdata(bus_rdata)
  );

  pcsr_ctrl #(.QMASK_W(QMASK_W), .FRAG_W(FRAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_irqen(wr_irqen), .wr_qcfg(wr_qcfg),
    .wd_en(bus_wdata[EN_BIT]), .wd_vfy(bus_wdata[VFY_BIT]),
    .wd_rsp(bus_wdata[RSP_BIT]), .wd_irqen(bus_wdata[IRQEN_BIT]),
    .wd_frag(bus_wdata[FRAG_LSB +: FRAG_W]),
    .wd_qmask(bus_wdata[QMASK_LSB +: QMASK_W]),
    .en_q(en_q), .vfy_req_q(vfy_req_q), .rsp_req_q(rsp_req_q),
    .irq_en_q(irq_en_q), .frag_q(frag_q), .qmask_q(qmask_q)
  );

  pcsr_status #(.NUM_EV(NUM_EV)) u_sts (
    .clk(clk), .rst_n(rst_n), .rd_clear(rd_clear),
    .ev(ev_vec), .flags_q(flags_q)
  );

  assign preempt_en      = en_q;
  assign tx_verify_req   = vfy_req_q;
  assign tx_response_req = rsp_req_q;
  assign frag_size       = frag_q;
  assign preempt_qmask   = qmask_q;
  assign irq             = irq_en_q & (|flags_q);
endmodule

// File: rtl/pcsr_checker.sv
module pcsr_checker #(
  parameter int ADDR_W = 4,
  parameter int NUM_EV = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NUM_EV-1:0] ev_vec,
  input logic [NUM_EV-1:0] flags_q,
  input logic              preempt_en,
  input logic              tx_verify_req,
  input logic              tx_response_req,
  input logic              irq
);
  logic wr0, rd0;
  assign wr0 = bus_sel & bus_wr & (bus_addr == '0);
  assign rd0 = bus_sel & ~bus_wr & (bus_addr == '0);

  // R3: a verify request traces back to a write of bit 1 one cycle earlier
  a_r3_verify_origin: assert property (@(posedge clk) disable iff (!rst_n)
    tx_verify_req |-> $past(wr0 && bus_wdata[1]));

  // R3: same for the response request
  a_r3_response_origin: assert property (@(posedge clk) disable iff (!rst_n)
    tx_response_req |-> $past(wr0 && bus_wdata[2]));

  // R2: the enable only moves on a write to word 0
  a_r2_enable_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !wr0 |=> $stable(preempt_en));

  // R6: any event leaves its flag set next cycle, read or not
  a_r6_event_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> ((flags_q & $past(ev_vec)) == $past(ev_vec)));

  // R5: a clearing read with no events leaves all flags clear
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && ev_vec == '0) |=> (flags_q == '0));

  // R10: without a clearing read, no flag ever falls
  a_r10_no_spurious_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !rd0 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R7: irq never rises without a flag behind it
  a_r7_irq_has_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != '0));
endmodule

bind pcsr_top pcsr_checker #(.ADDR_W(ADDR_W), .NUM_EV(pcsr_pkg::NUM_EV)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ev_vec(ev_vec),
  .flags_q(flags_q), .preempt_en(preempt_en), .tx_verify_req(tx_verify_req),
  .tx_response_req(tx_response_req), .irq(irq)
);

// File: tb/tb_pcsr_top.sv
module tb_pcsr_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [3:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic        ev_rv = 0, ev_rr = 0, ev_tv = 0, ev_tr = 0;
  logic        preempt_en, tx_verify_req, tx_response_req, irq;
  logic [1:0]  frag_size;
  logic [7:0]  preempt_qmask;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcsr_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ev_rx_verify(ev_rv), .ev_rx_response(ev_rr),
    .ev_tx_verify(ev_tv), .ev_tx_response(ev_tr),
    .preempt_en(preempt_en), .tx_verify_req(tx_verify_req),
    .tx_response_req(tx_response_req), .frag_size(frag_size),
    .preempt_qmask(preempt_qmask), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 0; bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0;
  endtask

  task automatic pulse_ev(input logic [3:0] m);
    @(negedge clk);
    {ev_tr, ev_tv, ev_rr, ev_rv} = m;
    @(posedge clk); #1;
    {ev_tr, ev_tv, ev_rr, ev_rv} = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 en", {31'b0, preempt_en}, 0);
    check("R1 irq", {31'b0, irq}, 0);
    check("R1 reqs", {30'b0, tx_verify_req, tx_response_req}, 0);
    check("R1 qcfg outs", {22'b0, preempt_qmask, frag_size}, 0);
    bus_read(0, d); check("R1 word0", d, 0);
    bus_read(1, d); check("R1 word1", d, 0);
    bus_read(2, d); check("R1 word2", d, 0);
  endtask

  task automatic t_enable_and_requests;
    logic [31:0] d;
    bus_write(0, 32'h1);
    check("R2 en set", {31'b0, preempt_en}, 1);
    bus_write(0, 32'h3);
    @(negedge clk);
    check("R3 verify strobe", {31'b0, tx_verify_req}, 1);
    check("R3 no resp strobe", {31'b0, tx_response_req}, 0);
    check("R2 en kept", {31'b0, preempt_en}, 1);
    @(negedge clk);
    check("R3 verify one cycle", {31'b0, tx_verify_req}, 0);
    bus_write(0, 32'h5);
    @(negedge clk);
    check("R3 resp strobe", {31'b0, tx_response_req}, 1);
    bus_read(0, d);
    check("R3 req bits read 0", d, 32'h1);
    check("R3 resp one cycle", {31'b0, tx_response_req}, 0);
    bus_write(0, 32'h6);
    check("R2 en cleared", {31'b0, preempt_en}, 0);
    @(negedge clk);
    check("R3 both strobes", {30'b0, tx_verify_req, tx_response_req}, 2'b11);
  endtask

  task automatic t_flags;
    logic [31:0] d;
    pulse_ev(4'b0001);
    pulse_ev(4'b0100);
    bus_read(1, d);
    bus_read(2, d);
    bus_read(0, d); check("R4 R10 flags 16,18", d, 32'h0005_0000);
    bus_read(0, d); check("R5 cleared", d, 0);
    pulse_ev(4'b1010);
    bus_write(0, 32'h000F_0000);
    bus_read(0, d); check("R4 R10 flags 17,19 write no effect", d, 32'h000A_0000);
    bus_write(0, 32'h000F_0000);
    bus_read(0, d); check("R10 write cannot set", d, 0);
  endtask

  task automatic t_collision;
    logic [31:0] d;
    pulse_ev(4'b0001);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 0; ev_rr = 1;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_sel = 0; ev_rr = 0;
    check("R6 read returns old", d, 32'h0001_0000);
    bus_read(0, d); check("R6 event kept", d, 32'h0002_0000);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    pulse_ev(4'b1000);
    @(negedge clk);
    check("R7 masked", {31'b0, irq}, 0);
    bus_read(0, d);
    bus_write(1, 32'h1);
    @(negedge clk);
    check("R8 no stale irq", {31'b0, irq}, 0);
    bus_read(1, d); check("R7 irqen readback", d, 1);
    pulse_ev(4'b0010);
    @(negedge clk);
    check("R7 irq raised", {31'b0, irq}, 1);
    bus_read(0, d);
    @(negedge clk);
    check("R7 irq cleared by read", {31'b0, irq}, 0);
    pulse_ev(4'b0100);
    bus_write(1, 32'h0);
    @(negedge clk);
    check("R7 irq gated off", {31'b0, irq}, 0);
    bus_read(0, d);
  endtask

  task automatic t_qcfg;
    logic [31:0] d;
    bus_write(2, 32'hFFFF_FFFF);
    check("R9 frag", {30'b0, frag_size}, 2'b11);
    check("R9 qmask", {24'b0, preempt_qmask}, 8'hFF);
    bus_read(2, d); check("R9 readback all", d, 32'h0000_FF03);
    bus_write(2, 32'h0000_A502);
    bus_read(2, d); check("R9 readback", d, 32'h0000_A502);
    check("R9 qmask pattern", {24'b0, preempt_qmask}, 8'hA5);
    bus_write(5, 32'hFFFF_FFFF);
    bus_read(5, d); check("R10 unmapped", d, 0);
    bus_read(2, d); check("R10 unmapped write ignored", d, 32'h0000_A502);
  endtask

  initial begin
    #(200000*CLK_PERIOD);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_enable_and_requests();
    t_flags();
    t_collision();
    t_irq();
    t_qcfg();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule